// File: doc/BRIEF.md
# Prioritized Task Dispatcher with Resumable Background Task

This block chooses which of eight hardware tasks an accelerator engine runs next. Each task has a trigger pulse input and a program start address. The block answers with a one-cycle load strobe, the address the engine must load into its program counter, and the number of the task now running. The engine reports the end of a foreground task with a completion pulse. Foreground tasks run to completion and never interrupt one another. Triggers that arrive while the engine is busy are held, and the most urgent one is served next. Task 1 is the most urgent and task 8 the least.

With the background option enabled, task 8 becomes a background task. A trigger starts it at a dedicated background address, and it then keeps running until a stop pulse ends it or the block is reset. A trigger on any of tasks 1 to 7 pre-empts it. At that edge the engine's current program address is captured into a return register. Once no foreground work is left, the background task is reloaded at that captured address. Background code can raise a no-pre-empt flag, which holds off pre-emption for as long as it stays high.

Top module: `task_dispatch`

## Requirements
- R1: After synchronous reset, load_o is 0, cur_task_o is 0 (idle) and bg_ret_o is 0.
- R2: With the engine idle, a trigger on task k (trig_i bit k-1) gives, at the next clock edge, load_o high for exactly one cycle, load_addr_o equal to vector k (vec_i bits (k-1)*ADDR_W upward) and cur_task_o equal to k.
- R3: When several foreground tasks are pending at a dispatch point, the lowest-numbered one is dispatched first.
- R4: A running foreground task is never pre-empted. Triggers that arrive meanwhile are latched, and repeated triggers of one task merge into a single run. After done_i, cur_task_o becomes 0 at the next edge and the next pending task loads one edge later.
- R5: With bg_en_i low, task 8 is an ordinary foreground task that uses vector 8.
- R6: With bg_en_i high, a trigger on task 8 starts the background task two edges later with load_addr_o = bg_vec_i and cur_task_o = 8. A done_i pulse leaves it running.
- R7: A trigger on task 1 to 7 while the background task is on the engine dispatches that task at the next edge and stores engine_pc_i from that edge into bg_ret_o.
- R8: The background task resumes at the stored address, with cur_task_o = 8, only once no foreground task is running or pending.
- R9: While the background task is on the engine and no_preempt_i is high, no load happens. A pending foreground task is dispatched at the first edge at which no_preempt_i is low.
- R10: A bg_stop_i pulse ends the background task: bg_ret_o becomes 0, cur_task_o becomes 0 if the background task was on the engine, and there is no resume until task 8 is triggered again. A later start uses bg_vec_i.
- R11: A task 8 trigger while the background task is already active causes no load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trig_i | input | N_TASKS | Per-task trigger pulses; bit 0 is task 1 |
| vec_i | input | N_TASKS*ADDR_W | Start address of each task, task 1 in the lowest bits |
| bg_vec_i | input | ADDR_W | Start address of the background task |
| bg_en_i | input | 1 | Makes task 8 a background task |
| done_i | input | 1 | Engine pulse: the current foreground task has finished |
| bg_stop_i | input | 1 | Terminates the background task |
| no_preempt_i | input | 1 | Background code forbids pre-emption while high |
| engine_pc_i | input | ADDR_W | Engine's current program address |
| load_o | output | 1 | One-cycle strobe: the engine loads load_addr_o |
| load_addr_o | output | ADDR_W | Address to load |
| cur_task_o | output | $clog2(N_TASKS+1) | Running task number, 0 when idle |
| bg_ret_o | output | ADDR_W | Stored background return address |

## Verification
The bench uses the default eight tasks and 16-bit addresses. With these values task 8 is the slot that can become the background task, and every priority position from 1 to 8 can be reached by the triggers. One random run keeps the background option on, where pre-emption, deferral, stop and resume interleave. A second run keeps it off, so task 8 competes as an ordinary lowest-priority task. A cycle model derived from the requirements is compared with all four outputs on every cycle.

// File: rtl/td_pkg.sv
package td_pkg;

  typedef enum logic [1:0] {
    DEC_IDLE   = 2'd0,
    DEC_FG     = 2'd1,
    DEC_RESUME = 2'd2
  } td_dec_e;

endpackage

// File: rtl/td_trig_latch.sv
module td_trig_latch #(
  parameter int N_TASKS = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_TASKS-1:0] trig_i,
  input  logic [N_TASKS-1:0] mask_i,
  input  logic [N_TASKS-1:0] clr_i,
  output logic [N_TASKS-1:0] eff_o
);

  logic [N_TASKS-1:0] pend_q;
  logic [N_TASKS-1:0] new_req;

  assign new_req = trig_i & mask_i;
  assign eff_o   = (pend_q | trig_i) & mask_i;

  always_ff @(posedge clk) begin
    if (rst) pend_q <= '0;
    else     pend_q <= (pend_q | new_req) & ~clr_i;
  end

  // a request that is not consumed at its own edge must stay pending
  AST_PEND_HOLD: assert property (@(posedge clk) disable iff (rst)
    ((new_req & ~clr_i) != '0) |=>
      ((pend_q & $past(new_req & ~clr_i)) == $past(new_req & ~clr_i))); // R4

endmodule

// File: rtl/td_prio_pick.sv
module td_prio_pick #(
  parameter int N_TASKS = 8,
  localparam int IDX_W  = (N_TASKS > 1) ? $clog2(N_TASKS) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_TASKS-1:0] req_i,
  output logic               valid_o,
  output logic [IDX_W-1:0]   idx_o
);

  logic [N_TASKS-1:0] seen;
  logic [N_TASKS-1:0] first;

  genvar g;
  generate
    for (g = 0; g < N_TASKS; g++) begin : g_chain
      if (g == 0) begin : g_head
        assign seen[g]  = req_i[g];
        assign first[g] = req_i[g];
      end else begin : g_tail
        assign seen[g]  = seen[g-1] | req_i[g];
        assign first[g] = req_i[g] & ~seen[g-1];
      end
    end
  endgenerate

  always_comb begin
    idx_o = '0;
    for (int i = 0; i < N_TASKS; i++) begin
      if (first[i]) idx_o = idx_o | IDX_W'(i);
    end
  end

  assign valid_o = seen[N_TASKS-1];

  logic [N_TASKS-1:0] below_mask;
  assign below_mask = (N_TASKS'(1) << idx_o) - N_TASKS'(1);

  AST_PICK_FIRST: assert property (@(posedge clk) disable iff (rst)
    valid_o |-> (req_i[idx_o] && ((req_i & below_mask) == '0))); // R3

  AST_PICK_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(first)); // R3

endmodule

// File: rtl/td_bg_ctx.sv
module td_bg_ctx #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              preempt_i,
  input  logic              resume_i,
  input  logic [ADDR_W-1:0] pc_i,
  output logic              run_o,
  output logic              on_o,
  output logic [ADDR_W-1:0] saved_o,
  output logic              saved_valid_o
);

  logic              run_q;
  logic              on_q;
  logic [ADDR_W-1:0] saved_q;
  logic              saved_v_q;
  logic              kick_out;

  assign kick_out = preempt_i & on_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q     <= 1'b0;
      on_q      <= 1'b0;
      saved_q   <= '0;
      saved_v_q <= 1'b0;
    end else if (stop_i) begin
      run_q     <= 1'b0;
      on_q      <= 1'b0;
      saved_q   <= '0;
      saved_v_q <= 1'b0;
    end else begin
      if (start_i) run_q <= 1'b1;
      if (kick_out) begin
        on_q      <= 1'b0;
        saved_q   <= pc_i;
        saved_v_q <= 1'b1;
      end else if (resume_i) begin
        on_q      <= 1'b1;
        saved_v_q <= 1'b0;
      end
    end
  end

  assign run_o         = run_q;
  assign on_o          = on_q;
  assign saved_o       = saved_q;
  assign saved_valid_o = saved_v_q;

  AST_ON_NEEDS_RUN: assert property (@(posedge clk) disable iff (rst)
    on_q |-> run_q); // R6

  AST_STOP_CLEARS: assert property (@(posedge clk) disable iff (rst)
    stop_i |=> (!run_q && !on_q && saved_q == '0)); // R10

  AST_SAVE_PC: assert property (@(posedge clk) disable iff (rst)
    (kick_out && !stop_i) |=> (saved_q == $past(pc_i) && saved_v_q)); // R7

endmodule

// File: rtl/task_dispatch.sv
module task_dispatch
  import td_pkg::*;
#(
  parameter int N_TASKS = 8,
  parameter int ADDR_W  = 16
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [N_TASKS-1:0]            trig_i,
  input  logic [N_TASKS*ADDR_W-1:0]     vec_i,
  input  logic [ADDR_W-1:0]             bg_vec_i,
  input  logic                          bg_en_i,
  input  logic                          done_i,
  input  logic                          bg_stop_i,
  input  logic                          no_preempt_i,
  input  logic [ADDR_W-1:0]             engine_pc_i,
  output logic                          load_o,
  output logic [ADDR_W-1:0]             load_addr_o,
  output logic [$clog2(N_TASKS+1)-1:0]  cur_task_o,
  output logic [ADDR_W-1:0]             bg_ret_o
);

  localparam int IDX_W = (N_TASKS > 1) ? $clog2(N_TASKS) : 1;
  localparam int CUR_W = $clog2(N_TASKS+1);
  localparam logic [CUR_W-1:0] BG_NUM = CUR_W'(N_TASKS);

  logic [N_TASKS-1:0] fg_mask;
  logic [N_TASKS-1:0] eff_req;
  logic [N_TASKS-1:0] clr_vec;
  logic               pick_valid;
  logic [IDX_W-1:0]   pick_idx;
  logic               bg_run;
  logic               bg_on;
  logic [ADDR_W-1:0]  bg_saved;
  logic               bg_saved_v;
  logic               blocked;
  logic               fg_busy_q;
  td_dec_e            dec;

  logic               load_q;
  logic [ADDR_W-1:0]  addr_q;
  logic [CUR_W-1:0]   cur_q;
  logic [ADDR_W-1:0]  next_addr;

  // task 8 leaves the foreground pool when it acts as background
  assign fg_mask = bg_en_i ? {1'b0, {(N_TASKS-1){1'b1}}} : {N_TASKS{1'b1}};

  td_trig_latch #(.N_TASKS(N_TASKS)) u_latch (
    .clk    (clk),
    .rst    (rst),
    .trig_i (trig_i),
    .mask_i (fg_mask),
    .clr_i  (clr_vec),
    .eff_o  (eff_req)
  );

  td_prio_pick #(.N_TASKS(N_TASKS)) u_pick (
    .clk     (clk),
    .rst     (rst),
    .req_i   (eff_req),
    .valid_o (pick_valid),
    .idx_o   (pick_idx)
  );

  assign blocked = bg_on & no_preempt_i;

  always_comb begin
    dec = DEC_IDLE;
    if (!fg_busy_q) begin
      if (pick_valid) begin
        if (!blocked) dec = DEC_FG;
      end else if (bg_run && !bg_on && !bg_stop_i && bg_en_i) begin
        dec = DEC_RESUME;
      end
    end
  end

  assign clr_vec = (dec == DEC_FG) ? (N_TASKS'(1) << pick_idx) : '0;

  td_bg_ctx #(.ADDR_W(ADDR_W)) u_bg (
    .clk           (clk),
    .rst           (rst),
    .start_i       (bg_en_i & trig_i[N_TASKS-1]),
    .stop_i        (bg_stop_i),
    .preempt_i     (dec == DEC_FG),
    .resume_i      (dec == DEC_RESUME),
    .pc_i          (engine_pc_i),
    .run_o         (bg_run),
    .on_o          (bg_on),
    .saved_o       (bg_saved),
    .saved_valid_o (bg_saved_v)
  );

  always_comb begin
    case (dec)
      DEC_FG:     next_addr = vec_i[int'(pick_idx)*ADDR_W +: ADDR_W];
      DEC_RESUME: next_addr = bg_saved_v ? bg_saved : bg_vec_i;
      default:    next_addr = addr_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      load_q    <= 1'b0;
      addr_q    <= '0;
      cur_q     <= '0;
      fg_busy_q <= 1'b0;
    end else begin
      load_q <= (dec != DEC_IDLE);
      addr_q <= next_addr;
      if (dec == DEC_FG)              fg_busy_q <= 1'b1;
      else if (done_i)                fg_busy_q <= 1'b0;
      if (dec == DEC_FG)              cur_q <= CUR_W'(pick_idx) + CUR_W'(1);
      else if (dec == DEC_RESUME)     cur_q <= BG_NUM;
      else if (fg_busy_q && done_i)   cur_q <= '0;
      else if (bg_stop_i && bg_on)    cur_q <= '0;
    end
  end

  assign load_o      = load_q;
  assign load_addr_o = addr_q;
  assign cur_task_o  = cur_q;
  assign bg_ret_o    = bg_saved;

  AST_FG_LOAD_PULSE: assert property (@(posedge clk) disable iff (rst)
    (load_o && cur_task_o != BG_NUM) |=> !load_o); // R2

  AST_FG_NO_PREEMPT: assert property (@(posedge clk) disable iff (rst)
    fg_busy_q |=> !load_o); // R4

  AST_DEFER_PREEMPT: assert property (@(posedge clk) disable iff (rst)
    (bg_on && no_preempt_i) |=> !load_o); // R9

  AST_CUR_RANGE: assert property (@(posedge clk) disable iff (rst)
    cur_task_o <= BG_NUM); // R2

  AST_RESET_IDLE: assert property (@(posedge clk)
    rst |=> (!load_o && cur_task_o == '0)); // R1

endmodule

// File: tb/task_dispatch_tb.sv
module task_dispatch_tb;

  localparam int CLK_PERIOD = 10;
  localparam int N  = 8;
  localparam int AW = 16;
  localparam logic [AW-1:0] BGV = 16'hB000;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [N-1:0]  trig = '0;
  logic [N*AW-1:0] vec;
  logic          bg_en = 1'b0;
  logic          done = 1'b0;
  logic          stop = 1'b0;
  logic          nopre = 1'b0;
  logic [AW-1:0] pc = '0;
  logic          load;
  logic [AW-1:0] addr;
  logic [3:0]    cur;
  logic [AW-1:0] ret;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 1'b0;
  bit model_go = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  task_dispatch #(.N_TASKS(N), .ADDR_W(AW)) u_dut (
    .clk(clk), .rst(rst), .trig_i(trig), .vec_i(vec), .bg_vec_i(BGV),
    .bg_en_i(bg_en), .done_i(done), .bg_stop_i(stop), .no_preempt_i(nopre),
    .engine_pc_i(pc), .load_o(load), .load_addr_o(addr), .cur_task_o(cur),
    .bg_ret_o(ret)
  );

  function automatic logic [AW-1:0] vof(int k);
    return 16'h1000 + AW'(k) * 16'h0100;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // cycle model built from the requirements
  logic [N-1:0]  m_pend;
  logic          m_busy, m_run, m_on, m_svv, m_load;
  logic [AW-1:0] m_sv, m_addr;
  logic [3:0]    m_cur;

  always @(posedge clk) begin
    logic [N-1:0] fgm, eff, clr;
    logic pv, dofg, dores;
    int pi;
    if (rst) begin
      m_pend = '0; m_busy = 0; m_run = 0; m_on = 0; m_svv = 0;
      m_sv = '0; m_load = 0; m_addr = '0; m_cur = '0;
    end else begin
      fgm = bg_en ? 8'h7F : 8'hFF;
      eff = (m_pend | trig) & fgm;
      pv = (eff != '0);
      pi = 0;
      for (int i = N-1; i >= 0; i--) if (eff[i]) pi = i;
      dofg  = !m_busy && pv && !(m_on && nopre);
      dores = !m_busy && !pv && m_run && !m_on && !stop && bg_en;
      m_load = dofg || dores;
      if (dofg) m_addr = vof(pi);
      else if (dores) m_addr = m_svv ? m_sv : BGV;
      if (dofg) m_cur = 4'(pi + 1);
      else if (dores) m_cur = 4'd8;
      else if (m_busy && done) m_cur = 0;
      else if (stop && m_on) m_cur = 0;
      clr = dofg ? (8'd1 << pi) : 8'd0;
      m_pend = (m_pend | (trig & fgm)) & ~clr;
      if (stop) begin
        m_run = 0; m_on = 0; m_sv = '0; m_svv = 0;
      end else begin
        if (bg_en && trig[N-1]) m_run = 1;
        if (dofg && m_on) begin m_on = 0; m_sv = pc; m_svv = 1; end
        else if (dores) begin m_on = 1; m_svv = 0; end
      end
      if (dofg) m_busy = 1; else if (done) m_busy = 0;
    end
  end

  always @(negedge clk) begin
    if (!rst && model_go) begin
      chk("R2 model load", 32'(load), 32'(m_load));
      chk("R2 model addr", 32'(addr), 32'(m_addr));
      chk("R3 model task", 32'(cur),  32'(m_cur));
      chk("R7 model ret",  32'(ret),  32'(m_sv));
    end
  end

  task automatic step();
    @(negedge clk);
  endtask

  task automatic pulse_trig(logic [N-1:0] m);
    trig = m; step(); trig = '0;
  endtask

  task automatic pulse_done();
    done = 1'b1; step(); done = 1'b0;
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    for (int k = 0; k < N; k++) vec[k*AW +: AW] = vof(k);
    step(); step(); rst = 1'b0; model_go = 1'b1; step();
    chk("R1 load", 32'(load), 0);
    chk("R1 task", 32'(cur), 0);
    chk("R1 ret",  32'(ret), 0);

    // plain foreground dispatch, task 8 ordinary
    pulse_trig(8'h04);
    chk("R2 load", 32'(load), 1); chk("R2 addr", 32'(addr), 32'(vof(2))); chk("R2 task", 32'(cur), 3);
    step(); chk("R2 single pulse", 32'(load), 0);
    pulse_trig(8'h11); chk("R4 no preempt", 32'(load), 0); chk("R4 task held", 32'(cur), 3);
    pulse_trig(8'h10);
    pulse_done(); chk("R4 idle after done", 32'(cur), 0); chk("R4 gap", 32'(load), 0);
    step(); chk("R3 first", 32'(addr), 32'(vof(0))); chk("R3 first task", 32'(cur), 1);
    pulse_done(); step(); chk("R3 second", 32'(cur), 5); chk("R3 second load", 32'(load), 1);
    pulse_done(); step(); step(); chk("R4 merged", 32'(load), 0); chk("R4 merged task", 32'(cur), 0);
    pulse_trig(8'h80); chk("R5 addr", 32'(addr), 32'(vof(7))); chk("R5 task", 32'(cur), 8);
    pulse_done(); chk("R5 done", 32'(cur), 0);

    // background task
    bg_en = 1'b1;
    pulse_trig(8'h80); chk("R6 start delay", 32'(load), 0);
    step(); chk("R6 load", 32'(load), 1); chk("R6 addr", 32'(addr), 32'(BGV)); chk("R6 task", 32'(cur), 8);
    pulse_done(); chk("R6 done ignored", 32'(cur), 8);
    pulse_trig(8'h80); chk("R11 retrig", 32'(load), 0);
    step(); chk("R11 retrig later", 32'(load), 0); chk("R11 task", 32'(cur), 8);
    pc = 16'h1234;
    pulse_trig(8'h02); pc = 16'h5555;
    chk("R7 load", 32'(load), 1); chk("R7 addr", 32'(addr), 32'(vof(1))); chk("R7 ret", 32'(ret), 32'h1234);
    pulse_trig(8'h08); chk("R8 latched", 32'(load), 0);
    pulse_done(); step(); chk("R8 pending first", 32'(cur), 4); chk("R8 pending addr", 32'(addr), 32'(vof(3)));
    pulse_done(); step(); chk("R8 resume load", 32'(load), 1); chk("R8 resume addr", 32'(addr), 32'h1234);
    chk("R8 resume task", 32'(cur), 8);
    nopre = 1'b1; pc = 16'h2222;
    pulse_trig(8'h01); chk("R9 deferred", 32'(load), 0); chk("R9 task", 32'(cur), 8);
    step(); step(); chk("R9 still deferred", 32'(load), 0);
    nopre = 1'b0; step();
    chk("R9 load", 32'(load), 1); chk("R9 task after", 32'(cur), 1); chk("R9 ret", 32'(ret), 32'h2222);
    stop = 1'b1; step(); stop = 1'b0;
    chk("R10 ret cleared", 32'(ret), 0); chk("R10 fg kept", 32'(cur), 1);
    pulse_done(); step(); step(); chk("R10 no resume", 32'(load), 0); chk("R10 idle", 32'(cur), 0);
    pulse_trig(8'h80); step();
    chk("R10 fresh start", 32'(addr), 32'(BGV)); chk("R6 restart task", 32'(cur), 8);
    stop = 1'b1; step(); stop = 1'b0;
    chk("R10 stop on engine", 32'(cur), 0);
    step(); step(); chk("R10 stays stopped", 32'(load), 0);

    // random phase, background on
    for (int c = 0; c < 3000; c++) begin
      logic [N-1:0] t;
      for (int b = 0; b < N; b++) t[b] = ($urandom % 14 == 0);
      trig = t;
      done = ($urandom % 5 == 0);
      stop = ($urandom % 120 == 0);
      if ($urandom % 9 == 0) nopre = ~nopre;
      pc = AW'($urandom);
      step();
    end
    trig = '0; done = 0; stop = 0; nopre = 0;

    // random phase, background off
    rst = 1'b1; step(); step(); bg_en = 1'b0; rst = 1'b0; step();
    chk("R1 second reset", 32'(cur), 0);
    for (int c = 0; c < 2000; c++) begin
      logic [N-1:0] t;
      for (int b = 0; b < N; b++) t[b] = ($urandom % 12 == 0);
      trig = t;
      done = ($urandom % 4 == 0);
      nopre = ($urandom % 2 == 0);
      pc = AW'($urandom);
      step();
    end
    trig = '0; done = 0;
    step();
    finished = 1'b1;
    summary();
    $finish;
  end

endmodule